// File: doc/BRIEF.md
# Display Identification Block Fetcher

This block reads the identification data that a display keeps in a small serial memory and decides whether it can be trusted. A single pulse on `start` launches a fixed sequence: the byte that says how many extension blocks follow is fetched first, then the 128-byte base block, and then one 128-byte extension block when that count is non-zero. Every byte of a block is added into a running 8-bit sum, and a block counts as good only when that sum wraps to zero on its final byte. A read error, or a block whose sum is not zero, ends the run at once with a fail result.

Reads go out on a byte-read request channel. Each request carries a device address and an offset and waits for a `ready` handshake. Each response returns one data byte or an error flag, and only one request is in flight at a time. Once every block needed has passed, the block reads the sink's test-request byte over a small sideband channel. When the sink is asking for an identification-read test, the block writes back the final byte of the last good block and then a completion flag. The run ends with a one-cycle `done` pulse, qualified by `pass`. `csum_out` holds the final byte of the most recently validated block.

Top module: `disp_id_fetch`

## Requirements
- R1: Every read request carries device address 0x50. A request holds its offset steady until `rd_req_ready` accepts it, and no new request is raised while a response is still owed.
- R2: The first read of every run is at offset 0x7E, the extension-count byte.
- R3: The base block is read at offsets 0 to 127 in ascending order. When the extension count is non-zero, offsets 128 to 255 are then read in the same way. When the count is zero, no offset of 128 or above is requested.
- R4: A block passes only if the modulo-256 sum of all 128 of its bytes is zero. A failing block ends the run with `pass` low and issues no further read or sideband request.
- R5: The extension block is requested only after the base block has passed, so a bad base block ends the run after 129 reads in all.
- R6: A response with `rd_rsp_err` high ends the run at once with `pass` low. This holds for the extension-count read too, and no further request follows.
- R7: `done` is high for exactly one cycle per run, and `pass` is high only in that cycle and only on success. `busy` is high from the cycle after `start` up to and including the `done` cycle. A `start` pulse while `busy` is high is ignored.
- R8: `csum_out` resets to 0. It takes the byte at offset 127 (or 255) of each block that passes, and keeps its value through any run or block that fails.
- R9: After the last needed block passes, a sideband read with select 0 fetches the test-request byte. If bit 2 of that byte is set, a sideband write of `csum_out` to select 1 follows, then a write of 0x04 to select 2, in that order. If bit 2 is clear, the run passes without any sideband write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a fetch run (pulse) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run result, valid with `done` |
| csum_out | output | 8 | Final byte of the last validated block |
| rd_req_valid | output | 1 | Byte-read request valid |
| rd_req_ready | input | 1 | Byte-read request accepted |
| rd_req_dev | output | 7 | Device address of the request |
| rd_req_off | output | 8 | Byte offset of the request |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 8 | Read response byte |
| rd_rsp_err | input | 1 | Read response error |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband request accepted |
| sb_req_wr | output | 1 | 1 = write, 0 = read |
| sb_req_sel | output | 2 | Register select: 0 test request, 1 test checksum, 2 test response |
| sb_req_wdata | output | 8 | Sideband write data |
| sb_rsp_valid | input | 1 | Sideband read response valid |
| sb_rsp_data | input | 8 | Sideband read response byte |

## Verification
Image patterns with extension count zero and non-zero separate the one-block path from the two-block path by the number and range of offsets requested. Images with a corrupt final byte in the base block or in the extension block show that the check is made per block and that `csum_out` keeps its last good value. Errors injected on the count read and in the middle of a block, together with test-request bytes that have bit 2 set and clear, separate early termination from the sideband write-back. A run with a stalling request `ready` and a stray `start` while busy shows that the handshake and the single-run rule hold.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CNT_REQ,
    ST_CNT_WAIT,
    ST_BLK_REQ,
    ST_BLK_WAIT,
    ST_TRQ_REQ,
    ST_TRQ_WAIT,
    ST_CSUM_WR,
    ST_RESP_WR,
    ST_GOOD,
    ST_BAD
  } fetch_state_e;

  localparam logic [1:0] SEL_TEST_REQ  = 2'd0;
  localparam logic [1:0] SEL_TEST_CSUM = 2'd1;
  localparam logic [1:0] SEL_TEST_RESP = 2'd2;

endpackage

// File: rtl/disp_id_sum.sv
module disp_id_sum #(
  parameter int BLOCK_BYTES = 128,
  localparam int CW = $clog2(BLOCK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [7:0]    byte_in,
  output logic [CW-1:0] idx,
  output logic          last,
  output logic          sum_zero
);

  logic [CW-1:0] idx_q, idx_d;
  logic [7:0]    sum_q, sum_d;
  logic          en;

  // running sum including the byte now arriving
  assign sum_zero = ((sum_q + byte_in) == 8'd0);
  assign last     = (idx_q == CW'(BLOCK_BYTES - 1));
  assign idx      = idx_q;
  assign en       = clr | take;

  always_comb begin
    idx_d = idx_q;
    sum_d = sum_q;
    if (clr) begin
      idx_d = '0;
      sum_d = 8'd0;
    end else if (take) begin
      idx_d = idx_q + CW'(1);
      sum_d = sum_q + byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sum_q <= 8'd0;
    end else if (en) begin
      idx_q <= idx_d;
      sum_q <= sum_d;
    end
  end

endmodule

// File: rtl/disp_id_seq.sv
module disp_id_seq
  import disp_id_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         BLOCK_BYTES = 128,
  parameter int         TEST_BIT    = 2,
  parameter logic [7:0] RESP_FLAG   = 8'h04,
  localparam int        CW          = $clog2(BLOCK_BYTES),
  localparam int        OFF_W       = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [7:0]       csum_out,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [6:0]       rd_req_dev,
  output logic [OFF_W-1:0] rd_req_off,
  input  logic             rd_rsp_valid,
  input  logic [7:0]       rd_rsp_data,
  input  logic             rd_rsp_err,
  output logic             sb_req_valid,
  input  logic             sb_req_ready,
  output logic             sb_req_wr,
  output logic [1:0]       sb_req_sel,
  output logic [7:0]       sb_req_wdata,
  input  logic             sb_rsp_valid,
  input  logic [7:0]       sb_rsp_data,
  output logic             sum_clr,
  output logic             sum_take,
  input  logic [CW-1:0]    blk_idx,
  input  logic             blk_last,
  input  logic             blk_sum_zero
);

  localparam logic [OFF_W-1:0] CNT_OFF = OFF_W'(BLOCK_BYTES - 2);

  fetch_state_e state_q, state_d;
  logic         ext_q, ext_d;       // an extension block follows the base
  logic         sel_q, sel_d;       // 0 base block, 1 extension block
  logic [7:0]   csum_q, csum_d;
  logic         ctl_en, csum_en;

  always_comb begin
    state_d  = state_q;
    ext_d    = ext_q;
    sel_d    = sel_q;
    csum_d   = csum_q;
    csum_en  = 1'b0;
    sum_clr  = 1'b0;
    sum_take = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_CNT_REQ;
      end
      ST_CNT_REQ: begin
        if (rd_req_ready) state_d = ST_CNT_WAIT;
      end
      ST_CNT_WAIT: begin
        if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            state_d = ST_BAD;
          end else begin
            ext_d   = |rd_rsp_data;
            sel_d   = 1'b0;
            sum_clr = 1'b1;
            state_d = ST_BLK_REQ;
          end
        end
      end
      ST_BLK_REQ: begin
        if (rd_req_ready) state_d = ST_BLK_WAIT;
      end
      ST_BLK_WAIT: begin
        if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            state_d = ST_BAD;
          end else begin
            sum_take = 1'b1;
            if (!blk_last) begin
              state_d = ST_BLK_REQ;
            end else if (!blk_sum_zero) begin
              state_d = ST_BAD;
            end else begin
              csum_d  = rd_rsp_data;
              csum_en = 1'b1;
              if (ext_q && !sel_q) begin
                sel_d   = 1'b1;
                sum_clr = 1'b1;
                state_d = ST_BLK_REQ;
              end else begin
                state_d = ST_TRQ_REQ;
              end
            end
          end
        end
      end
      ST_TRQ_REQ: begin
        if (sb_req_ready) state_d = ST_TRQ_WAIT;
      end
      ST_TRQ_WAIT: begin
        if (sb_rsp_valid) state_d = sb_rsp_data[TEST_BIT] ? ST_CSUM_WR : ST_GOOD;
      end
      ST_CSUM_WR: begin
        if (sb_req_ready) state_d = ST_RESP_WR;
      end
      ST_RESP_WR: begin
        if (sb_req_ready) state_d = ST_GOOD;
      end
      ST_GOOD, ST_BAD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ext_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      ext_q   <= ext_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csum_q <= 8'd0;
    else if (csum_en) csum_q <= csum_d;
  end

  // outputs decoded from state
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_GOOD) || (state_q == ST_BAD);
  assign pass         = (state_q == ST_GOOD);
  assign csum_out     = csum_q;
  assign rd_req_valid = (state_q == ST_CNT_REQ) || (state_q == ST_BLK_REQ);
  assign rd_req_dev   = DEV_ADDR;
  assign rd_req_off   = (state_q == ST_CNT_REQ) ? CNT_OFF : {sel_q, blk_idx};

  always_comb begin
    sb_req_valid = 1'b0;
    sb_req_wr    = 1'b0;
    sb_req_sel   = SEL_TEST_REQ;
    sb_req_wdata = 8'd0;
    unique case (state_q)
      ST_TRQ_REQ: sb_req_valid = 1'b1;
      ST_CSUM_WR: begin
        sb_req_valid = 1'b1;
        sb_req_wr    = 1'b1;
        sb_req_sel   = SEL_TEST_CSUM;
        sb_req_wdata = csum_q;
      end
      ST_RESP_WR: begin
        sb_req_valid = 1'b1;
        sb_req_wr    = 1'b1;
        sb_req_sel   = SEL_TEST_RESP;
        sb_req_wdata = RESP_FLAG;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/disp_id_fetch.sv
module disp_id_fetch #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         BLOCK_BYTES = 128,
  parameter int         TEST_BIT    = 2,
  parameter logic [7:0] RESP_FLAG   = 8'h04,
  localparam int        CW          = $clog2(BLOCK_BYTES),
  localparam int        OFF_W       = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [7:0]       csum_out,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [6:0]       rd_req_dev,
  output logic [OFF_W-1:0] rd_req_off,
  input  logic             rd_rsp_valid,
  input  logic [7:0]       rd_rsp_data,
  input  logic             rd_rsp_err,
  output logic             sb_req_valid,
  input  logic             sb_req_ready,
  output logic             sb_req_wr,
  output logic [1:0]       sb_req_sel,
  output logic [7:0]       sb_req_wdata,
  input  logic             sb_rsp_valid,
  input  logic [7:0]       sb_rsp_data
);

  logic          sum_clr, sum_take, blk_last, blk_sum_zero;
  logic [CW-1:0] blk_idx;

  disp_id_sum #(.BLOCK_BYTES(BLOCK_BYTES)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sum_clr),
    .take     (sum_take),
    .byte_in  (rd_rsp_data),
    .idx      (blk_idx),
    .last     (blk_last),
    .sum_zero (blk_sum_zero)
  );

  disp_id_seq #(
    .DEV_ADDR    (DEV_ADDR),
    .BLOCK_BYTES (BLOCK_BYTES),
    .TEST_BIT    (TEST_BIT),
    .RESP_FLAG   (RESP_FLAG)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .pass         (pass),
    .csum_out     (csum_out),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_dev   (rd_req_dev),
    .rd_req_off   (rd_req_off),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .rd_rsp_err   (rd_rsp_err),
    .sb_req_valid (sb_req_valid),
    .sb_req_ready (sb_req_ready),
    .sb_req_wr    (sb_req_wr),
    .sb_req_sel   (sb_req_sel),
    .sb_req_wdata (sb_req_wdata),
    .sb_rsp_valid (sb_rsp_valid),
    .sb_rsp_data  (sb_rsp_data),
    .sum_clr      (sum_clr),
    .sum_take     (sum_take),
    .blk_idx      (blk_idx),
    .blk_last     (blk_last),
    .blk_sum_zero (blk_sum_zero)
  );

endmodule

// File: rtl/disp_id_fetch_chk.sv
module disp_id_fetch_chk #(
  parameter int         OFF_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         CNT_OFF  = 126
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic [7:0]       csum_out,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [6:0]       rd_req_dev,
  input logic [OFF_W-1:0] rd_req_off,
  input logic             rd_rsp_valid,
  input logic             sb_req_valid,
  input logic             sb_req_ready,
  input logic             sb_req_wr,
  input logic [1:0]       sb_req_sel
);

  logic owed_q, first_q, csum_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q    <= 1'b0;
      first_q   <= 1'b1;
      csum_wr_q <= 1'b0;
    end else begin
      if (rd_req_valid && rd_req_ready) owed_q <= 1'b1;
      else if (rd_rsp_valid)            owed_q <= 1'b0;
      if (!busy)                                     first_q <= 1'b1;
      else if (rd_req_valid && rd_req_ready)         first_q <= 1'b0;
      if (done)                                      csum_wr_q <= 1'b0;
      else if (sb_req_valid && sb_req_ready && sb_req_wr && sb_req_sel == 2'd1)
                                                     csum_wr_q <= 1'b1;
    end
  end

  // R1
  dev_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_dev == DEV_ADDR);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_off));

  // R1
  single_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !owed_q);

  // R2
  first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && first_q |-> rd_req_off == OFF_W'(CNT_OFF));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  pass_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && busy);

  // R8
  csum_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csum_out) |-> $past(rd_rsp_valid));

  // R9
  resp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid && sb_req_wr && sb_req_sel == 2'd2 |-> csum_wr_q);

endmodule

bind disp_id_fetch disp_id_fetch_chk #(
  .OFF_W    (OFF_W),
  .DEV_ADDR (DEV_ADDR),
  .CNT_OFF  (BLOCK_BYTES - 2)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .pass         (pass),
  .csum_out     (csum_out),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_dev   (rd_req_dev),
  .rd_req_off   (rd_req_off),
  .rd_rsp_valid (rd_rsp_valid),
  .sb_req_valid (sb_req_valid),
  .sb_req_ready (sb_req_ready),
  .sb_req_wr    (sb_req_wr),
  .sb_req_sel   (sb_req_sel)
);

// File: tb/disp_id_fetch_bench.sv
module disp_id_fetch_bench;

  logic       clk, rst_n, start;
  logic       busy, done, pass;
  logic [7:0] csum_out;
  logic       rd_req_valid, rd_req_ready;
  logic [6:0] rd_req_dev;
  logic [7:0] rd_req_off;
  logic       rd_rsp_valid, rd_rsp_err;
  logic [7:0] rd_rsp_data;
  logic       sb_req_valid, sb_req_ready, sb_req_wr;
  logic [1:0] sb_req_sel;
  logic [7:0] sb_req_wdata;
  logic       sb_rsp_valid;
  logic [7:0] sb_rsp_data;

  disp_id_fetch u_disp_id_fetch (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int cycles = 0;

  // sink model state
  logic [7:0] mem [0:255];
  logic [7:0] test_req;
  int  err_off = -1;
  int  rd_count, bad_dev, order_bad, max_off;
  int  exp_off;
  int  sb_rd_count, sb_wr_count;
  logic [1:0] wr_sel [0:3];
  logic [7:0] wr_dat [0:3];
  bit  stall_mode = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    rd_count = 0; bad_dev = 0; order_bad = 0; max_off = -1; exp_off = 126;
    sb_rd_count = 0; sb_wr_count = 0;
  endtask

  // fill one 128-byte block; corrupt makes its sum non-zero
  task automatic fill_block(input int base, input int seed, input int cnt_val, input bit corrupt);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < 127; i++) begin
      mem[base+i] = 8'((seed * 29 + i * 13 + (i >> 3)) & 255);
      if (base == 0 && i == 126) mem[base+i] = 8'(cnt_val);
      s = s + mem[base+i];
    end
    mem[base+127] = 8'(0) - s + (corrupt ? 8'd1 : 8'd0);
  endtask

  // read responder: one cycle after acceptance
  initial begin
    bit pend;
    int poff;
    pend = 0; poff = 0;
    rd_rsp_valid = 0; rd_rsp_err = 0; rd_rsp_data = 0; rd_req_ready = 1;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 0; rd_rsp_err = 0;
      rd_req_ready = stall_mode ? ((cycles % 3) != 0) : 1'b1;
      if (pend) begin
        rd_rsp_valid = 1;
        rd_rsp_data  = mem[poff];
        rd_rsp_err   = (poff == err_off);
        pend = 0;
      end else if (rd_req_valid && rd_req_ready) begin
        pend = 1; poff = int'(rd_req_off);
        rd_count++;
        if (rd_req_dev != 7'h50) bad_dev++;
        if (poff != exp_off) order_bad++;
        exp_off = (rd_count == 1) ? 0 : poff + 1;
        if (poff > max_off && rd_count > 1) max_off = poff;
      end
    end
  end

  // sideband responder
  initial begin
    bit pend;
    pend = 0;
    sb_rsp_valid = 0; sb_rsp_data = 0; sb_req_ready = 1;
    forever begin
      @(negedge clk);
      sb_rsp_valid = 0;
      if (pend) begin
        sb_rsp_valid = 1; sb_rsp_data = test_req; pend = 0;
      end else if (sb_req_valid && sb_req_ready) begin
        if (sb_req_wr) begin
          if (sb_wr_count < 4) begin
            wr_sel[sb_wr_count] = sb_req_sel;
            wr_dat[sb_wr_count] = sb_req_wdata;
          end
          sb_wr_count++;
        end else begin
          pend = 1; sb_rd_count++;
          if (sb_req_sel != 2'd0) sb_wr_count += 100;
        end
      end
    end
  end

  task automatic run(output bit p, input bit poke_start);
    int w;
    bit seen_done;
    clear_log();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    w = 0; seen_done = 0; p = 0;
    while (!seen_done && w < 2000) begin
      if (poke_start && w == 40) start = 1;
      if (poke_start && w == 41) start = 0;
      if (done) begin seen_done = 1; p = pass; end
      @(negedge clk); w++;
    end
    check(seen_done, "R7 done seen", seen_done, 1);
    check(!done && !pass, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(rd_count == rd_count && !busy, "R7 idle after run", busy, 0);
    check(bad_dev == 0, "R1 device address", bad_dev, 0);
  endtask

  task automatic t_reset();
    check(!done && !pass && !busy, "R7 reset outputs", done, 0);
    check(!rd_req_valid && !sb_req_valid, "R1 reset no request", rd_req_valid, 0);
    check(csum_out == 8'd0, "R8 reset csum", csum_out, 0);
  endtask

  task automatic t_one_block();
    bit p;
    fill_block(0, 3, 0, 0); fill_block(128, 5, 0, 0); test_req = 8'h00;
    run(p, 0);
    check(p, "R4 one block pass", p, 1);
    check(rd_count == 129, "R3 one block read count", rd_count, 129);
    check(order_bad == 0, "R2 R3 offset order", order_bad, 0);
    check(max_off == 127, "R3 no extension offsets", max_off, 127);
    check(sb_rd_count == 1 && sb_wr_count == 0, "R9 bit clear no writes", sb_wr_count, 0);
    check(csum_out == mem[127], "R8 base csum", csum_out, mem[127]);
  endtask

  task automatic t_two_blocks(input bit stall, input bit poke);
    bit p;
    fill_block(0, 7, 1, 0); fill_block(128, 11, 0, 0); test_req = 8'h04;
    stall_mode = stall;
    run(p, poke);
    stall_mode = 0;
    check(p, "R4 two block pass", p, 1);
    check(rd_count == 257, "R3 R7 two block read count", rd_count, 257);
    check(order_bad == 0, "R3 two block order", order_bad, 0);
    check(sb_wr_count == 2, "R9 write count", sb_wr_count, 2);
    check(wr_sel[0] == 2'd1 && wr_dat[0] == mem[255], "R9 csum write", wr_dat[0], mem[255]);
    check(wr_sel[1] == 2'd2 && wr_dat[1] == 8'h04, "R9 response write", wr_dat[1], 4);
    check(csum_out == mem[255], "R8 ext csum", csum_out, mem[255]);
  endtask

  task automatic t_bad_base();
    bit p;
    logic [7:0] keep;
    keep = csum_out;
    fill_block(0, 13, 2, 1); fill_block(128, 17, 0, 0); test_req = 8'h04;
    run(p, 0);
    check(!p, "R4 bad base fails", p, 0);
    check(rd_count == 129, "R5 stop after base", rd_count, 129);
    check(sb_rd_count == 0 && sb_wr_count == 0, "R4 no sideband after fail", sb_rd_count, 0);
    check(csum_out == keep, "R8 csum kept on fail", csum_out, keep);
  endtask

  task automatic t_bad_ext();
    bit p;
    fill_block(0, 19, 1, 0); fill_block(128, 23, 0, 1); test_req = 8'h04;
    run(p, 0);
    check(!p, "R4 bad extension fails", p, 0);
    check(rd_count == 257, "R4 extension fully read", rd_count, 257);
    check(csum_out == mem[127], "R8 base csum survives", csum_out, mem[127]);
    check(sb_rd_count == 0, "R4 no test read", sb_rd_count, 0);
  endtask

  task automatic t_err_mid();
    bit p;
    fill_block(0, 29, 1, 0); fill_block(128, 31, 0, 0); test_req = 8'h00;
    err_off = 10;
    run(p, 0);
    err_off = -1;
    check(!p, "R6 mid-block error fails", p, 0);
    check(rd_count == 12, "R6 stop at error", rd_count, 12);
  endtask

  task automatic t_err_cnt();
    bit p;
    fill_block(0, 37, 0, 0); test_req = 8'h00;
    err_off = 126;
    run(p, 0);
    err_off = -1;
    check(!p, "R6 count read error fails", p, 0);
    check(rd_count == 1, "R6 single read", rd_count, 1);
  endtask

  task automatic t_one_block_test();
    bit p;
    fill_block(0, 41, 0, 0); test_req = 8'hFF;
    run(p, 0);
    check(p, "R9 one block with test", p, 1);
    check(sb_wr_count == 2 && wr_dat[0] == mem[127], "R9 base csum written", wr_dat[0], mem[127]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    rst_n = 0; start = 0; test_req = 0;
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_one_block();
    t_two_blocks(0, 0);
    t_bad_base();
    t_bad_ext();
    t_err_mid();
    t_err_cnt();
    t_one_block_test();
    t_two_blocks(1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule